// File: doc/BRIEF.md
# Flash Controller Event Status and Interrupt Unit

This unit gathers the event flags raised by a flash command engine into one 13-bit status register and condenses them into a single interrupt line. Software sees three locations on a simple strobe bus: a control word that carries a 12-bit interrupt mask and a run bit, the status word, and a command-word port that forwards words to the engine only while the unit is running.

Status bits are sticky. A hardware event sets its bit, and software clears any of the low twelve bits by writing ones to them. Each mask bit is an active-high disable for the status bit in the same position. The unit raises the write-command request itself when software starts it. The engine ends a run with a finish pulse, and software can abort a run, which wipes the whole status word. When the functional clock has been stopped and restarted, a restart pulse puts the status word into its both-ready pattern.

Top module: `nfc_stat_irq`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0x0000_0FFF (every mask bit set, run clear), the irq output is 0 and cmd_push is 0.
- R2: A 1 on evt_set[k] for k in 12..1 sets status bit k at the next clock edge, and the bit stays set until it is cleared. The status positions are: 0 write-command request, 1 read-data request, 2 write-data request, 3 single-bit ECC error, 4 double-bit ECC error, 6/5 bad block on chip select 0/1, 8/7 command done on chip select 0/1, 10/9 page done on chip select 0/1, 11 flash ready, 12 controller ready.
- R3: A bus write to address 1 clears every status bit among 11..0 whose write-data bit is 1. Bits written as 0 are unchanged, and bit 12 cannot be cleared by a write.
- R4: If a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Control bits 11..0 are mask bits, and a 1 disables the matching status bit. irq equals the OR of the unmasked status bits 11..0 as they stood one clock earlier. Status bit 12 never drives irq.
- R6: evt_set[0] sets status bit 0 only while run is 1. A control write that takes run (bit 28) from 0 to 1 sets status bit 0 at the same edge.
- R7: A bus write to address 2 while run is 1 produces cmd_push = 1 with cmd_word equal to the written data in the next cycle. While run is 0, such a write is dropped and cmd_push stays 0.
- R8: A cmd_finish pulse clears run at the next edge. A control write in the same cycle takes precedence.
- R9: A control write that takes run from 1 to 0 clears all 13 status bits at the next edge, including bits whose events arrive in that cycle.
- R10: A fclk_restart pulse makes the status word 0x1800 at the next edge, overriding every other update.
- R11: Reads are combinational while bus_rd is 1. Address 0 returns the mask in bits 11..0 and run in bit 28, with all other bits 0. Address 1 returns the status word zero-extended. Addresses 2 and 3 read 0. bus_rdata is 0 whenever bus_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | 0 control, 1 status, 2 command word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| evt_set | input | 13 | Event set pulses from the command engine |
| cmd_finish | input | 1 | Command finished, clears run |
| fclk_restart | input | 1 | Functional clock restarted |
| run | output | 1 | Run bit |
| cmd_push | output | 1 | Command word valid for one cycle |
| cmd_word | output | 32 | Forwarded command word |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit in the status word is visible at a read of address 1 in the same cycle as the fault. It also reaches irq one clock later whenever that bit is unmasked. A corrupted mask or run bit first shows up at a control read. It also shows through its side effects one edge later: a dropped or extra cmd_push, a missing write-command request, or an abort that leaves status behind. The bench therefore compares irq, cmd_push and the read data against a bench model in every cycle, so a divergence is reported within one clock of its cause.

// File: rtl/nfc_stat_pkg.sv
package nfc_stat_pkg;
   typedef enum logic [1:0] {
      ADR_CTRL = 2'd0,
      ADR_STAT = 2'd1,
      ADR_CMDW = 2'd2,
      ADR_NONE = 2'd3
   } nfc_addr_e;
endpackage

// File: rtl/nfc_ctl_reg.sv
module nfc_ctl_reg #(
   parameter int MASK_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic              wr_run,
   input  logic              cmd_finish,
   output logic [MASK_W-1:0] mask_q,
   output logic              run_q,
   output logic              run_rise,
   output logic              abort
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         run_q  <= 1'b0;
      end else if (ctl_wr) begin
         mask_q <= wr_mask;
         run_q  <= wr_run;
      end else if (cmd_finish) begin
         run_q  <= 1'b0;
      end
   end

   assign run_rise = ctl_wr &  wr_run & ~run_q;
   assign abort    = ctl_wr & ~wr_run &  run_q;

   assert_run_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_finish && !ctl_wr) |=> !run_q);
endmodule

// File: rtl/nfc_sts_reg.sv
module nfc_sts_reg #(
   parameter int                EVT_W       = 13,
   parameter int                MASK_W      = 12,
   parameter logic [EVT_W-1:0]  RESTART_VAL = 13'h1800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  set_vec,
   input  logic [MASK_W-1:0] clr_vec,
   input  logic              abort,
   input  logic              restart,
   output logic [EVT_W-1:0]  sts_q
);
   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      if (i < MASK_W) begin : g_w1c
         always_ff @(posedge clk) begin
            if (!rst_n)             sts_q[i] <= 1'b0;
            else if (restart)       sts_q[i] <= RESTART_VAL[i];
            else if (abort)         sts_q[i] <= 1'b0;
            else if (set_vec[i])    sts_q[i] <= 1'b1;
            else if (clr_vec[i])    sts_q[i] <= 1'b0;
         end
      end else begin : g_ro
         always_ff @(posedge clk) begin
            if (!rst_n)             sts_q[i] <= 1'b0;
            else if (restart)       sts_q[i] <= RESTART_VAL[i];
            else if (abort)         sts_q[i] <= 1'b0;
            else if (set_vec[i])    sts_q[i] <= 1'b1;
         end
      end
   end

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !abort && ((set_vec[MASK_W-1:0] & clr_vec) != '0))
      |=> ((sts_q[MASK_W-1:0] & $past(set_vec[MASK_W-1:0] & clr_vec))
           == $past(set_vec[MASK_W-1:0] & clr_vec)));
endmodule

// File: rtl/nfc_irq_out.sv
module nfc_irq_out #(
   parameter int MASK_W  = 12,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MASK_W-1:0] sts_low,
   input  logic [MASK_W-1:0] mask,
   output logic              irq
);
   logic hit;
   assign hit = |(sts_low & ~mask);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= hit;
      end
      assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ((sts_low & ~mask) == '0) |=> !irq);
   end else begin : g_comb
      assign irq = hit;
   end
endmodule

// File: rtl/nfc_stat_irq.sv
module nfc_stat_irq #(
   parameter int               DATA_W      = 32,
   parameter int               EVT_W       = 13,
   parameter int               MASK_W      = 12,
   parameter int               RUN_POS     = 28,
   parameter bit               IRQ_REG     = 1'b1,
   parameter logic [EVT_W-1:0] RESTART_VAL = 13'h1800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [EVT_W-1:0]  evt_set,
   input  logic              cmd_finish,
   input  logic              fclk_restart,
   output logic              run,
   output logic              cmd_push,
   output logic [DATA_W-1:0] cmd_word,
   output logic              irq
);
   import nfc_stat_pkg::*;

   if (MASK_W >= EVT_W) begin : g_chk_mask
      $error("MASK_W must be below EVT_W");
   end
   if (EVT_W > DATA_W || RUN_POS >= DATA_W || RUN_POS < MASK_W) begin : g_chk_pos
      $error("field positions do not fit the data word");
   end

   logic              ctl_wr, sts_wr, cmd_wr;
   logic [MASK_W-1:0] mask;
   logic              run_rise, abort;
   logic [EVT_W-1:0]  set_vec, sts;
   logic [MASK_W-1:0] clr_vec;

   assign ctl_wr = bus_wr && (nfc_addr_e'(bus_addr) == ADR_CTRL);
   assign sts_wr = bus_wr && (nfc_addr_e'(bus_addr) == ADR_STAT);
   assign cmd_wr = bus_wr && (nfc_addr_e'(bus_addr) == ADR_CMDW);

   nfc_ctl_reg #(.MASK_W(MASK_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
      .wr_mask(bus_wdata[MASK_W-1:0]), .wr_run(bus_wdata[RUN_POS]),
      .cmd_finish(cmd_finish), .mask_q(mask), .run_q(run),
      .run_rise(run_rise), .abort(abort));

   assign set_vec = {evt_set[EVT_W-1:1], (evt_set[0] & run) | run_rise};
   assign clr_vec = sts_wr ? bus_wdata[MASK_W-1:0] : '0;

   nfc_sts_reg #(.EVT_W(EVT_W), .MASK_W(MASK_W), .RESTART_VAL(RESTART_VAL)) u_sts (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .abort(abort), .restart(fclk_restart), .sts_q(sts));

   nfc_irq_out #(.MASK_W(MASK_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .sts_low(sts[MASK_W-1:0]), .mask(mask), .irq(irq));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_push <= 1'b0;
         cmd_word <= '0;
      end else begin
         cmd_push <= cmd_wr && run;
         if (cmd_wr && run) cmd_word <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (nfc_addr_e'(bus_addr))
            ADR_CTRL: begin
               bus_rdata[MASK_W-1:0] = mask;
               bus_rdata[RUN_POS]    = run;
            end
            ADR_STAT: bus_rdata[EVT_W-1:0] = sts;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!abort && !fclk_restart)
      |=> ((sts[EVT_W-1:1] & $past(evt_set[EVT_W-1:1])) == $past(evt_set[EVT_W-1:1])));
   assert_req_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ctl_wr && !fclk_restart && !sts[0]) |=> !sts[0]);
   assert_cmd_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !run) |=> !cmd_push);
   assert_abort_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !fclk_restart) |=> (sts == '0));
   assert_restart_val_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fclk_restart |=> (sts == RESTART_VAL));
endmodule

// File: tb/nfc_stat_irq_test.sv
`timescale 1ns/100ps
module nfc_stat_irq_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr, bus_rd;
   logic [1:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic [12:0] evt_set;
   logic        cmd_finish, fclk_restart;
   logic        run, cmd_push, irq;
   logic [31:0] cmd_word;

   always #2.5 clk = ~clk;

   nfc_stat_irq uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_set(evt_set), .cmd_finish(cmd_finish), .fclk_restart(fclk_restart),
      .run(run), .cmd_push(cmd_push), .cmd_word(cmd_word), .irq(irq));

   int n_vec = 0;
   int n_bad = 0;

   logic [12:0] m_sts;
   logic [11:0] m_mask;
   logic        m_run, m_irq, m_push;
   logic [31:0] m_word;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic rd, input logic [1:0] a);
      logic [31:0] v = '0;
      if (rd) begin
         if (a == 2'd0) begin v[11:0] = m_mask; v[28] = m_run; end
         else if (a == 2'd1) v[12:0] = m_sts;
      end
      return v;
   endfunction

   task automatic m_reset();
      m_sts = '0; m_mask = 12'hFFF; m_run = 1'b0; m_irq = 1'b0;
      m_push = 1'b0; m_word = '0;
   endtask

   task automatic m_step();
      logic        cw, sw, qw, rise, abrt;
      logic [12:0] setv;
      logic [11:0] clrv;
      cw = bus_wr && bus_addr == 2'd0;
      sw = bus_wr && bus_addr == 2'd1;
      qw = bus_wr && bus_addr == 2'd2;
      rise = cw && bus_wdata[28] && !m_run;
      abrt = cw && !bus_wdata[28] && m_run;
      m_irq = |(m_sts[11:0] & ~m_mask);
      setv = {evt_set[12:1], (evt_set[0] && m_run) || rise};
      clrv = sw ? bus_wdata[11:0] : 12'h000;
      if (fclk_restart) m_sts = 13'h1800;
      else if (abrt)    m_sts = '0;
      else              m_sts = (m_sts & ~{1'b0, clrv}) | setv;
      m_push = qw && m_run;
      if (qw && m_run) m_word = bus_wdata;
      if (cw) begin m_mask = bus_wdata[11:0]; m_run = bus_wdata[28]; end
      else if (cmd_finish) m_run = 1'b0;
   endtask

   task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [31:0] wd, input logic [12:0] ev,
                      input logic fin, input logic rs, input string tag);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
      evt_set = ev; cmd_finish = fin; fclk_restart = rs;
      #1;
      chk("R5 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R7 push", {31'd0, cmd_push}, {31'd0, m_push});
      if (m_push) chk("R7 word", cmd_word, m_word);
      chk("R8 run", {31'd0, run}, {31'd0, m_run});
      chk(tag, bus_rdata, m_read(rd, a));
      @(posedge clk);
      m_step();
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      rst_n = 1'b0;
      bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
      evt_set = 0; cmd_finish = 0; fclk_restart = 0;
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cyc(0, 1, 2'd0, 0, 0, 0, 0, "R1 ctrl reset");
      cyc(0, 1, 2'd1, 0, 0, 0, 0, "R1 status reset");
      // R7 command word dropped while not running
      cyc(1, 0, 2'd2, 32'hDEAD_BEEF, 0, 0, 0, "R7 drop");
      // R6 request event ignored while not running
      cyc(0, 0, 2'd0, 0, 13'h0001, 0, 0, "R6 gated");
      cyc(0, 1, 2'd1, 0, 0, 0, 0, "R6 bit0 still clear");
      // R6 run rise raises request, unmask all
      cyc(1, 0, 2'd0, 32'h1000_0000, 0, 0, 0, "R6 start");
      cyc(0, 1, 2'd1, 0, 0, 0, 0, "R6 bit0 set");
      cyc(1, 0, 2'd2, 32'h1234_5678, 0, 0, 0, "R7 accept");
      // R4 set beats clear on bit 3
      cyc(1, 0, 2'd1, 32'h0000_0008, 13'h0008, 0, 0, "R4 collide");
      cyc(0, 1, 2'd1, 0, 0, 0, 0, "R4 bit3 kept");
      // R3 clear all low bits, bit 12 survives
      cyc(0, 0, 2'd0, 0, 13'h1FFE, 0, 0, "R2 set many");
      cyc(1, 1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0, "R3 before clear");
      cyc(0, 1, 2'd1, 0, 0, 0, 0, "R3 after clear");
      // R5 masked bits do not interrupt
      cyc(1, 0, 2'd0, 32'h1000_0FFF, 13'h0010, 0, 0, "R5 mask all");
      cyc(0, 1, 2'd0, 0, 0, 0, 0, "R5 ctrl");
      cyc(0, 0, 2'd0, 0, 0, 0, 0, "R5 quiet");
      // R8 finish clears run
      cyc(0, 0, 2'd0, 0, 0, 1, 0, "R8 finish");
      cyc(0, 1, 2'd0, 0, 0, 0, 0, "R8 run clear");
      // R9 abort wipes status even with events
      cyc(1, 0, 2'd0, 32'h1000_0000, 0, 0, 0, "R9 restart run");
      cyc(1, 0, 2'd0, 32'h0000_0000, 13'h0F0F, 0, 0, "R9 abort");
      cyc(0, 1, 2'd1, 0, 0, 0, 0, "R9 status zero");
      // R10 clock restart pattern
      cyc(1, 0, 2'd1, 32'h0000_0FFF, 13'h00FF, 0, 1, "R10 restart");
      cyc(0, 1, 2'd1, 0, 0, 0, 0, "R10 value");
      // R11 unused addresses and idle read
      cyc(0, 1, 2'd3, 0, 0, 0, 0, "R11 addr3");
      cyc(0, 1, 2'd2, 0, 0, 0, 0, "R11 addr2");
      cyc(0, 0, 2'd1, 0, 0, 0, 0, "R11 no rd");
      // random mix
      for (int k = 0; k < 4000; k++) begin
         logic [31:0] r, wd;
         logic [12:0] ev;
         r  = $urandom;
         wd = $urandom;
         ev = 13'($urandom & $urandom & $urandom);
         if (r[7:4] == 4'd0) wd[28] = ~wd[28];
         cyc(r[0] & r[1], r[2] | r[3], r[9:8], wd, ev,
             r[15:12] == 4'd0, r[23:17] == 7'd0, "R2 random read");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule